// File: doc/BRIEF.md
# Codec Power State Controller

This block keeps the power state of one audio function group on a serial audio link. Power state requests arrive as a 3-bit code with a one-cycle valid strobe. The block reports the state actually reached on a status output. Entry into the deepest state (D4) takes a programmable number of cycles, so software can poll the status before it stops the bit clock. In D3 and D4 the block raises a flag that permits the link clock to stop. That flag clears only when software asks for D0, D1 or D2.

The block also decides how a pending event reaches the host. When the link is held in reset and the function group is in D3, the event becomes a single wake pulse. When the link is up and the bit clock runs, the event becomes a single unsolicited-response pulse. After a wake, the state is still reported as D3, and the held event then goes out as an unsolicited response once the link has restarted. A streaming-allowed flag lets stream logic run as soon as D0 is reached again. Register contents are not touched by any power transition.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After reset the actual state is D0, the clock-stop flag is 0, the wake and unsolicited outputs are 0, and streaming is allowed.
- R2: State codes are D0=0, D1=1, D2=2, D3=3, D4=4. When a valid request for D0 to D3 is accepted at a clock edge, `act_state_o` shows that code after the same edge.
- R3: A request with code 5, 6 or 7 is ignored. The actual state and the clock-stop flag stay unchanged.
- R4: A D4 request accepted at edge e0 leaves the old state visible until edge e0+D4_CYCLES, where the state becomes D4. Every request that arrives during the transition is ignored.
- R5: The clock-stop flag sets when a D3 request is accepted. It stays set through D3 and D4 requests and clears when a D0, D1 or D2 request is accepted.
- R6: In D3 with `link_rst_i` high, an asserted `evt_pend_i` gives `wake_o` high for exactly one cycle, one clock edge later. There is no second pulse until `evt_pend_i` has been low.
- R7: In D0 to D3 with `link_rst_i` low and `bclk_run_i` high, an asserted `evt_pend_i` gives `unsol_o` high for exactly one cycle, one edge later, with no wake. It gives one pulse per assertion of `evt_pend_i`.
- R8: If an event that caused a wake stays asserted, one unsolicited pulse follows once the link leaves reset with the clock running. The state stays D3 throughout.
- R9: With the link out of reset and the bit clock stopped, or in D4, no pulse is produced. The event stays pending and is delivered once the conditions of R7 hold.
- R10: `stream_en_o` is high exactly when the actual state is D0 and no D4 transition is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle strobe for a power state request |
| req_state_i | input | 3 | Requested state code |
| link_rst_i | input | 1 | Link held in reset |
| bclk_run_i | input | 1 | Bit clock is running |
| evt_pend_i | input | 1 | Event pending (level) |
| act_state_o | output | 3 | Actual power state |
| clk_stop_ok_o | output | 1 | Link clock may be stopped |
| wake_o | output | 1 | Wake request pulse |
| unsol_o | output | 1 | Unsolicited response request pulse |
| stream_en_o | output | 1 | Streams may run |

## Verification
The assertions assume that `evt_pend_i` is a level that stays high until its event has been delivered. They also assume that requests are single-cycle strobes whose code is stable while the strobe is high. The bench changes every input only on the falling clock edge. It holds the event level across each delivery and releases it before the next scenario. Link reset and bit clock changes are made only while no event is pending, or on purpose to show the deferral of R9.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_D0 = 3'd0,
    PS_D1 = 3'd1,
    PS_D2 = 3'd2,
    PS_D3 = 3'd3,
    PS_D4 = 3'd4
  } pstate_e;

  function automatic logic code_ok(input logic [2:0] c);
    return c <= 3'd4;
  endfunction
endpackage

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
#(
  parameter int unsigned D4_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_state_i,
  output pstate_e    act_o,
  output logic       busy_o,
  output logic       clk_stop_ok_o
);
  localparam int unsigned CW = $clog2(D4_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept = req_valid_i && !busy_o && code_ok(req_state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o         <= PS_D0;
      busy_o        <= 1'b0;
      cnt_q         <= '0;
      clk_stop_ok_o <= 1'b0;
    end else begin
      if (accept) begin
        if (req_state_i == PS_D4) begin
          busy_o <= 1'b1;
          cnt_q  <= CW'(D4_CYCLES);
        end else begin
          act_o <= pstate_e'(req_state_i);
        end
        // sticky: only a D0..D2 request clears it
        if (req_state_i <= 3'd2)      clk_stop_ok_o <= 1'b0;
        else if (req_state_i == 3'd3) clk_stop_ok_o <= 1'b1;
      end else if (busy_o) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          act_o  <= PS_D4;
          busy_o <= 1'b0;
        end
      end
    end
  end

  AST_UNDEF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && req_state_i > 3'd4) |=> ($stable(act_o) && $stable(clk_stop_ok_o))); // R3
  AST_D4_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q > CW'(1)) |=> $stable(act_o)); // R4
  AST_CLKSTOP_D3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o == PS_D3) |-> clk_stop_ok_o); // R5
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import pwr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pstate_e act_i,
  input  logic    evt_pend_i,
  input  logic    link_rst_i,
  input  logic    bclk_run_i,
  output logic    wake_o,
  output logic    unsol_o
);
  logic wake_sent_q, unsol_sent_q;
  logic fire_wake, fire_unsol;

  assign fire_unsol = evt_pend_i && !unsol_sent_q && !link_rst_i && bclk_run_i
                      && (act_i != PS_D4);
  assign fire_wake  = evt_pend_i && !wake_sent_q && !unsol_sent_q && link_rst_i
                      && (act_i == PS_D3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_o       <= 1'b0;
      unsol_o      <= 1'b0;
      wake_sent_q  <= 1'b0;
      unsol_sent_q <= 1'b0;
    end else begin
      wake_o       <= fire_wake;
      unsol_o      <= fire_unsol;
      wake_sent_q  <= evt_pend_i && (wake_sent_q || fire_wake);
      unsol_sent_q <= evt_pend_i && (unsol_sent_q || fire_unsol);
    end
  end

  AST_WAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R6
  AST_UNSOL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsol_o |=> !unsol_o); // R7
  AST_NO_EVT_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_pend_i |=> (!wake_o && !unsol_o)); // R9
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import pwr_pkg::*;
#(
  parameter int unsigned D4_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_state_i,
  input  logic       link_rst_i,
  input  logic       bclk_run_i,
  input  logic       evt_pend_i,
  output logic [2:0] act_state_o,
  output logic       clk_stop_ok_o,
  output logic       wake_o,
  output logic       unsol_o,
  output logic       stream_en_o
);
  pstate_e act;
  logic    busy;

  pwr_state_fsm #(.D4_CYCLES(D4_CYCLES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_state_i  (req_state_i),
    .act_o        (act),
    .busy_o       (busy),
    .clk_stop_ok_o(clk_stop_ok_o)
  );

  evt_arbiter u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .evt_pend_i(evt_pend_i),
    .link_rst_i(link_rst_i),
    .bclk_run_i(bclk_run_i),
    .wake_o    (wake_o),
    .unsol_o   (unsol_o)
  );

  assign act_state_o = act;
  assign stream_en_o = (act == PS_D0) && !busy;

  AST_WAKE_IN_D3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (act_state_o == 3'd3)); // R6
  AST_STREAM_D0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stream_en_o |-> (act_state_o == 3'd0)); // R10
endmodule

// File: tb/sim_codec_pwr_ctrl.sv
module sim_codec_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, link_rst = 1'b0, bclk_run = 1'b1, evt = 1'b0;
  logic [2:0] req_state = '0;
  logic [2:0] act;
  logic cso, wake, unsol, sen;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_pwr_ctrl #(.D4_CYCLES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_state_i(req_state),
    .link_rst_i(link_rst), .bclk_run_i(bclk_run), .evt_pend_i(evt),
    .act_state_o(act), .clk_stop_ok_o(cso), .wake_o(wake), .unsol_o(unsol),
    .stream_en_o(sen)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic request(input logic [2:0] c);
    req_valid = 1'b1; req_state = c;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 act", act, 0); chk("R1 clk_stop", cso, 0);
    chk("R1 wake", wake, 0); chk("R1 unsol", unsol, 0); chk("R1 stream", sen, 1);
  endtask

  task automatic t_basic();
    request(3'd1); chk("R2 act D1", act, 1); chk("R10 stream off D1", sen, 0);
    request(3'd2); chk("R2 act D2", act, 2);
    request(3'd0); chk("R2 act D0", act, 0); chk("R10 stream on D0", sen, 1);
  endtask

  task automatic t_undef();
    request(3'd6); chk("R3 act after 6", act, 0); chk("R3 clk_stop after 6", cso, 0);
    request(3'd3);
    request(3'd7); chk("R3 act after 7", act, 3); chk("R3 clk_stop kept", cso, 1);
  endtask

  task automatic t_d4();
    request(3'd4); chk("R4 old state at accept", act, 3);
    for (int i = 1; i <= N - 2; i++) begin
      tick(); chk("R4 old state held", act, 3);
    end
    request(3'd0); chk("R4 request in transition ignored", act, 3);
    tick(); chk("R4 D4 reached", act, 4);
    chk("R5 clk_stop in D4", cso, 1); chk("R10 stream off D4", sen, 0);
  endtask

  task automatic t_d4_quiet();
    evt = 1'b1; link_rst = 1'b0; bclk_run = 1'b1;
    tick(); chk("R9 no unsol in D4", unsol, 0);
    tick(); chk("R9 no wake in D4", wake, 0);
    evt = 1'b0; tick();
  endtask

  task automatic t_wake();
    request(3'd3); chk("R5 clk_stop D3 again", cso, 1);
    link_rst = 1'b1; bclk_run = 1'b0; evt = 1'b1;
    tick(); chk("R6 wake pulse", wake, 1); chk("R6 no unsol", unsol, 0);
    tick(); chk("R6 wake single", wake, 0);
    tick(); chk("R6 no rewake", wake, 0);
    link_rst = 1'b0; bclk_run = 1'b1;
    tick(); chk("R8 queued unsol", unsol, 1); chk("R8 still D3", act, 3);
    tick(); chk("R8 unsol single", unsol, 0); chk("R8 no wake", wake, 0);
    evt = 1'b0; tick();
    evt = 1'b1;
    tick(); chk("R7 unsol in D3 link up", unsol, 1); chk("R7 no wake in D3", wake, 0);
    evt = 1'b0; tick();
  endtask

  task automatic t_unsol_d2();
    request(3'd2); chk("R5 clk_stop cleared", cso, 0);
    evt = 1'b1;
    tick(); chk("R7 unsol in D2", unsol, 1);
    tick(); chk("R7 one per event", unsol, 0);
    evt = 1'b0; tick();
  endtask

  task automatic t_clk_stopped();
    bclk_run = 1'b0; evt = 1'b1;
    tick(); chk("R9 no unsol clock stopped", unsol, 0);
    tick(); chk("R9 no wake clock stopped", wake, 0);
    bclk_run = 1'b1;
    tick(); chk("R9 pending delivered", unsol, 1);
    evt = 1'b0; tick();
  endtask

  task automatic t_resume();
    request(3'd4);
    repeat (N) tick();
    chk("R4 D4 before resume", act, 4);
    request(3'd0); chk("R2 D4 to D0", act, 0); chk("R10 stream resumes", sen, 1);
    chk("R5 clk_stop clear in D0", cso, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_undef();
    t_d4();
    t_d4_quiet();
    t_wake();
    t_unsol_d2();
    t_clk_stopped();
    t_resume();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule